// File: doc/BRIEF.md
# Flash Erase Verification Scanner

This block confirms that a region of a 16-bit-wide flash array really holds erased contents. A requester gives it a byte start address and a byte count. The block first writes the command that returns the device to plain array reads. It then reads the region word by word, starting at the lowest address, and tests each word for the all-ones erased value.

The scan stops at the first word that is not erased. The block reports that word's byte address and the value it read, so software can see both where the region failed and what it found there. If every word in the region is erased, it reports a pass.

Each bus access keeps its strobe asserted for a fixed number of cycles, set by a parameter, so that the block can match a slow asynchronous array. It is intended to run after an erase, before programming begins.

Top module: `blank_scan_top`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fl_we` and `fl_re` are 0, and `fail_addr` and `fail_data` are 0.
- R2: For a request of nonzero length, the first bus access is a write of 16'h00FF (return to array reads) to the word-aligned start address. No read happens before that write.
- R3: Each bus access holds its strobe (`fl_we` or `fl_re`) for exactly `ACC_CYC` cycles, with address and data stable. Read data is sampled in the last of those cycles. `fl_we` and `fl_re` are never high together.
- R4: Reads go to consecutive word addresses, beginning at the word-aligned start address and rising by 2 bytes per read.
- R5: A word counts as erased only when it reads 16'hFFFF. At the first word that reads anything else, the block pulses `done` with `pass`=0, sets `fail_addr` to that word's byte address and `fail_data` to its value, and makes no further reads.
- R6: When every word below start+length reads 16'hFFFF, the block pulses `done` with `pass`=1, after exactly ceil(length/2) reads.
- R7: A length of 0 raises `done` with `pass`=1 in the cycle after the request is taken, with no bus access at all.
- R8: An odd length is rounded up to the next even value, so the word holding the last byte is still read.
- R9: A `start` that arrives while `busy` is 1 is ignored. The running scan, its reads and its result are unchanged.
- R10: `done` is high for one cycle only. `pass`, `fail_addr` and `fail_data` keep their values until the next request is taken, and they clear to 0 when it is.
- R11: Bit 0 of `start_addr` is ignored. The scan begins at the word that contains that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| start_addr | input | ADDR_W | Byte start address of region |
| start_len | input | LEN_W | Region length in bytes |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Region was fully erased |
| fail_addr | output | ADDR_W | Byte address of first non-erased word |
| fail_data | output | 16 | Value read at that word |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 16 | Flash write data (command) |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 16 | Flash read data |

## Verification
The hardest cases to reach from the ports are a premature data sample and a scan that skips the mode command. Both go unnoticed against a flash model that always returns valid array data. The bench flash model therefore returns a non-erased junk word until the read strobe has been held for the full access time. It also starts every scan in a status mode that answers 16'h0080 until it sees the 16'h00FF write, so either fault turns a blank region into a reported failure. A stray `start` is injected in the middle of a failing scan to show that the result still belongs to the first request.

// File: rtl/blank_scan_pkg.sv
package blank_scan_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] CMD_ARRAY_READ = 16'h00FF;
  localparam logic [WORD_W-1:0] ERASED_WORD    = 16'hFFFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD_REQ,
    S_CMD_WAIT,
    S_RD_REQ,
    S_RD_WAIT
  } scan_state_e;
endpackage

// File: rtl/flash_bus_seq.sv
module flash_bus_seq
  import blank_scan_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int ACC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              ack,
  output logic [WORD_W-1:0] rd_q,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [WORD_W-1:0] fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [WORD_W-1:0] fl_rdata
);
  localparam int CNT_W = $clog2(ACC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active = fl_we | fl_re;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_addr  <= '0;
      fl_wdata <= '0;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
      cnt_q    <= '0;
      ack      <= 1'b0;
      rd_q     <= '0;
    end else begin
      ack <= 1'b0;
      if (!active) begin
        if (req_wr || req_rd) begin
          fl_addr  <= req_addr;
          fl_wdata <= req_wdata;
          fl_we    <= req_wr;
          fl_re    <= req_rd & ~req_wr;
          cnt_q    <= CNT_LOAD;
        end
      end else if (cnt_q == '0) begin
        fl_we <= 1'b0;
        fl_re <= 1'b0;
        ack   <= 1'b1;
        if (fl_re) rd_q <= fl_rdata;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R3: strobes exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));
  // R3: controller never requests while an access is in flight
  p_no_req_busy_r3: assert property (@(posedge clk) disable iff (rst)
    active |-> !(req_wr || req_rd));
  // R3: address held while read strobe stays high
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (fl_re && !ack) |=> (!fl_re || $stable(fl_addr)));
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import blank_scan_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [WORD_W-1:0] fail_data,
  output logic              req_wr,
  output logic              req_rd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              ack,
  input  logic [WORD_W-1:0] rd_q
);
  localparam int EXT_W = ADDR_W + 1;

  scan_state_e      st_q;
  logic [EXT_W-1:0] cur_q, end_q, next_a, base_ext, end_n;
  logic [LEN_W:0]   len_round;
  logic             take, last_word;

  assign take      = start && (st_q == S_IDLE);
  assign len_round = {1'b0, start_len} + {{LEN_W{1'b0}}, start_len[0]};
  assign base_ext  = {1'b0, start_addr[ADDR_W-1:1], 1'b0};
  assign end_n     = base_ext + EXT_W'(len_round);
  assign next_a    = cur_q + EXT_W'(2);
  assign last_word = (next_a >= end_q);

  assign busy      = (st_q != S_IDLE);
  assign req_wr    = (st_q == S_CMD_REQ);
  assign req_rd    = (st_q == S_RD_REQ);
  assign req_addr  = cur_q[ADDR_W-1:0];
  assign req_wdata = CMD_ARRAY_READ;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      cur_q     <= '0;
      end_q     <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_addr <= '0;
      fail_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        S_IDLE: if (take) begin
          pass      <= 1'b0;
          fail_addr <= '0;
          fail_data <= '0;
          cur_q     <= base_ext;
          end_q     <= end_n;
          if (start_len == '0) begin
            done <= 1'b1;
            pass <= 1'b1;
          end else begin
            st_q <= S_CMD_REQ;
          end
        end
        S_CMD_REQ:  st_q <= S_CMD_WAIT;
        S_CMD_WAIT: if (ack) st_q <= S_RD_REQ;
        S_RD_REQ:   st_q <= S_RD_WAIT;
        S_RD_WAIT: if (ack) begin
          if (rd_q != ERASED_WORD) begin
            done      <= 1'b1;
            fail_addr <= cur_q[ADDR_W-1:0];
            fail_data <= rd_q;
            st_q      <= S_IDLE;
          end else if (last_word) begin
            done <= 1'b1;
            pass <= 1'b1;
            st_q <= S_IDLE;
          end else begin
            cur_q <= next_a;
            st_q  <= S_RD_REQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: results only move with a completion or a taken request
  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !take |=> (done || ($stable(pass) && $stable(fail_addr) && $stable(fail_data))));
  // R7: zero length completes next cycle as a pass
  p_zero_len_r7: assert property (@(posedge clk) disable iff (rst)
    (take && start_len == '0) |=> (done && pass && !busy));
  // R5: a failure never reports the erased value
  p_fail_data_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !pass) |-> (fail_data != ERASED_WORD));
  // R2: reads only come after the command state
  p_cmd_first_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RD_REQ) |-> ($past(st_q) == S_CMD_WAIT || $past(st_q) == S_RD_WAIT));
endmodule

// File: rtl/blank_scan_top.sv
module blank_scan_top
  import blank_scan_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 24,
  parameter int ACC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [15:0]       fail_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [15:0]       fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [15:0]       fl_rdata
);
  logic              req_wr, req_rd, ack;
  logic [ADDR_W-1:0] req_addr;
  logic [WORD_W-1:0] req_wdata, rd_q;

  scan_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .pass(pass),
    .fail_addr(fail_addr), .fail_data(fail_data), .req_wr(req_wr),
    .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rd_q(rd_q)
  );

  flash_bus_seq #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC)) u_bus (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rd_q(rd_q),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata)
  );
endmodule

// File: tb/test_blank_scan_top.sv
`timescale 1ns/1ps
module test_blank_scan_top;
  localparam int AW  = 16;
  localparam int LW  = 16;
  localparam int ACC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic busy, done, pass, fl_we, fl_re;
  logic [AW-1:0] fail_addr, fl_addr;
  logic [15:0] fail_data, fl_wdata, fl_rdata;

  always #2.5 clk = ~clk;

  blank_scan_top #(.ADDR_W(AW), .LEN_W(LW), .ACC_CYC(ACC)) i_blank_scan_top (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .pass(pass),
    .fail_addr(fail_addr), .fail_data(fail_data), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  // flash model: status mode until 00FF written; junk until access time met
  logic [15:0] mem [0:255];
  logic        array_mode = 1'b0;
  logic        knock = 1'b0;
  logic        log_clr = 1'b0;
  int          re_cnt = 0;
  logic        re_d = 1'b0;
  logic        wr_seen = 1'b0;
  int          rd_n = 0, wr_n = 0, rd_early = 0, done_n = 0;
  logic [AW-1:0] wr_addr_l;
  logic [15:0]   wr_data_l;
  logic [AW-1:0] rd_log [0:255];

  assign fl_rdata = (fl_re && re_cnt >= ACC - 1)
                    ? (array_mode ? mem[fl_addr[8:1]] : 16'h0080) : 16'h5A5A;

  always @(posedge clk) begin
    re_cnt <= fl_re ? re_cnt + 1 : 0;
    re_d   <= fl_re;
    if (fl_we && fl_wdata == 16'h00FF) array_mode <= 1'b1;
    else if (knock) array_mode <= 1'b0;
    if (log_clr) begin
      rd_n <= 0; wr_n <= 0; rd_early <= 0; wr_seen <= 1'b0; done_n <= 0;
    end else begin
      if (done) done_n <= done_n + 1;
      if (fl_we && !wr_seen) begin
        wr_seen <= 1'b1; wr_n <= wr_n + 1;
        wr_addr_l <= fl_addr; wr_data_l <= fl_wdata;
      end
      if (fl_re && !re_d) begin
        if (!wr_seen) rd_early <= rd_early + 1;
        if (rd_n < 256) rd_log[rd_n] <= fl_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic erase_all();
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
  endtask

  // runs one request; optional stray start while busy
  task automatic run_scan(input logic [AW-1:0] a, input logic [LW-1:0] l,
                          input bit exp_pass, input logic [AW-1:0] exp_fa,
                          input logic [15:0] exp_fd, input int exp_reads,
                          input string req, input bit stray);
    int cyc;
    logic [AW-1:0] base;
    base = {a[AW-1:1], 1'b0};
    @(negedge clk); knock = 1'b1; log_clr = 1'b1;
    @(negedge clk); knock = 1'b0; log_clr = 1'b0;
    start_addr = a; start_len = l; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (stray && cyc == 12) begin
        start_addr = 16'h00F0; start_len = 16'd0; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    chk(done, req, "done seen (watchdog)", done, 1);
    chk(pass == exp_pass, req, "pass", pass, exp_pass);
    chk(fail_addr == (exp_pass ? '0 : exp_fa), req, "fail_addr", fail_addr,
        exp_pass ? 0 : exp_fa);
    chk(fail_data == (exp_pass ? '0 : exp_fd), req, "fail_data", fail_data,
        exp_pass ? 0 : exp_fd);
    chk(rd_n == exp_reads, req, "read count", rd_n, exp_reads);
    if (l == 0) begin
      chk(cyc == 1, "R7", "zero length latency", cyc, 1);
      chk(wr_n == 0, "R7", "zero length bus writes", wr_n, 0);
    end else begin
      chk(wr_n == 1 && wr_data_l == 16'h00FF && wr_addr_l == base, "R2",
          "mode command data", wr_data_l, 16'h00FF);
      chk(rd_early == 0, "R2", "reads before command", rd_early, 0);
    end
    for (int i = 0; i < rd_n && i < 256; i++)
      chk(rd_log[i] == base + AW'(2*i), "R4", "read address", rd_log[i],
          base + AW'(2*i));
    @(negedge clk);
    chk(!done, "R10", "done after one cycle", done, 0);
    repeat (6) @(negedge clk);
    chk(pass == exp_pass && busy == 1'b0, "R10", "result held", pass, exp_pass);
    chk(done_n == 1, "R10", "done pulse count", done_n, 1);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !pass, "R1", "busy/done/pass", {busy, done, pass}, 0);
    chk(fail_addr == 0 && fail_data == 0, "R1", "fail regs", fail_data, 0);
    chk(!fl_we && !fl_re, "R1", "strobes", {fl_we, fl_re}, 0);
  endtask

  task automatic t_all_blank();      // R6
    erase_all();
    run_scan(16'h0010, 16'd8, 1'b1, '0, '0, 4, "R6", 1'b0);
  endtask

  task automatic t_mid_fail();       // R5
    erase_all(); mem[8'h12] = 16'hFFFE; mem[8'h14] = 16'h0000;
    run_scan(16'h0020, 16'd16, 1'b0, 16'h0024, 16'hFFFE, 3, "R5", 1'b0);
  endtask

  task automatic t_first_fail();     // R5 first word
    erase_all(); mem[8'h30] = 16'h0000;
    run_scan(16'h0060, 16'd10, 1'b0, 16'h0060, 16'h0000, 1, "R5", 1'b0);
  endtask

  task automatic t_odd_len();        // R8
    erase_all(); mem[8'h1A] = 16'h00FF;
    run_scan(16'h0030, 16'd5, 1'b0, 16'h0034, 16'h00FF, 3, "R8", 1'b0);
    erase_all();
    run_scan(16'h0030, 16'd5, 1'b1, '0, '0, 3, "R8", 1'b0);
  endtask

  task automatic t_zero_len();       // R7
    run_scan(16'h0040, 16'd0, 1'b1, '0, '0, 0, "R7", 1'b0);
  endtask

  task automatic t_odd_start();      // R11
    erase_all();
    run_scan(16'h0051, 16'd4, 1'b1, '0, '0, 2, "R11", 1'b0);
  endtask

  task automatic t_busy_ignore();    // R9
    erase_all(); mem[8'h24] = 16'h1234;
    run_scan(16'h0040, 16'd32, 1'b0, 16'h0048, 16'h1234, 5, "R9", 1'b1);
  endtask

  task automatic t_access_time();    // R3: strobe width observed at pins
    int w;
    erase_all();
    @(negedge clk); knock = 1'b1; log_clr = 1'b1;
    @(negedge clk); knock = 1'b0; log_clr = 1'b0;
    start_addr = 16'h0080; start_len = 16'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!fl_we) @(negedge clk);
    w = 0;
    while (fl_we) begin w++; @(negedge clk); end
    chk(w == ACC, "R3", "write strobe width", w, ACC);
    while (!fl_re) @(negedge clk);
    w = 0;
    while (fl_re) begin w++; @(negedge clk); end
    chk(w == ACC, "R3", "read strobe width", w, ACC);
    while (!done) @(negedge clk);
    chk(pass, "R3", "pass with full access time", pass, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    erase_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_blank();
    t_mid_fail();
    t_first_fail();
    t_odd_len();
    t_zero_len();
    t_odd_start();
    t_busy_ignore();
    t_access_time();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule